// File: doc/BRIEF.md
# Configurable Lookup-Table RAM

This block is a tiny register-based memory built from two 16-bit storage arrays, each addressed by its own 4-bit address group. A static organisation select turns the same two arrays into a 16x2 memory, a 32x1 memory, or a 16x1 memory with one write port and two independent read ports. Logic that needs a small scratch table, a shallow FIFO or a delay line can pick whichever shape it needs without a different macro.

Reads are purely combinational in every organisation. Writes happen on one edge of the write clock, and the write enable acts as a clock enable. A configuration input picks whether the rising edge or the falling edge of `clk` is the active write edge. Organisation and polarity are meant to be set while reset is held and then left alone.

Top module: `cfg_lut_ram`

## Requirements
- R1: While `rst_n` is low every cell of both arrays is cleared. After release, every read in every organisation returns 0 until something is written.
- R2: With `org_sel` = 2'b00, or the alias 2'b11, the memory is 16x2. On an active edge with `wr_en` = 1, `din0` is stored in the first array at `addr_a` and `din1` in the second array at `addr_b`. `dout0` shows first-array[`addr_a`] and `dout1` shows second-array[`addr_b`].
- R3: With `org_sel` = 2'b01 the memory is 32x1. `din1` is the fifth address bit: 0 selects the first array and 1 selects the second, at location `addr_a`, for both the write and the read. `din0` is the only write data. `dout0` shows the selected bit.
- R4: With `org_sel` = 2'b01, `dout1` is held at 0 and `addr_b` has no effect.
- R5: With `org_sel` = 2'b10 the memory is a 16x1 dual-port memory. A write stores `din0` at `addr_a` in both arrays. `dout0` reads location `addr_a` and `dout1` reads location `addr_b`.
- R6: Read data follows the address with no clock edge. When a read address equals the address being written, the old value is shown before the active edge and the new value after it.
- R7: An active edge with `wr_en` = 0 changes no cell.
- R8: With `clk_fall_sel` = 0 writes take place on the rising edge of `clk`. With `clk_fall_sel` = 1 they take place on the falling edge, and a rising edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the write clock |
| clk_fall_sel | input | 1 | 0: rising edge writes, 1: falling edge writes |
| org_sel | input | 2 | Organisation: 00 16x2, 01 32x1, 10 dual-port 16x1, 11 same as 00 |
| wr_en | input | 1 | Write enable, active high, acts as a clock enable |
| din0 | input | 1 | Write data for the first array, or the only write data |
| din1 | input | 1 | Write data for the second array in 16x2; fifth address bit in 32x1 |
| addr_a | input | 4 | First address group |
| addr_b | input | 4 | Second address group |
| dout0 | output | 1 | First read data |
| dout1 | output | 1 | Second read data |

## Verification
The assertions are sampled on the active write edge. They assume that `org_sel` and `clk_fall_sel` change only while reset is held, and that the address and data inputs are steady around each active edge. The stimulus follows both rules: it changes polarity and reset together, and it drives every input one nanosecond after the inactive edge. A reference model of both arrays is updated at each active edge, and every read is compared against it.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
  typedef enum logic [1:0] {
    ORG_WIDE = 2'b00,
    ORG_DEEP = 2'b01,
    ORG_DUAL = 2'b10,
    ORG_ALT  = 2'b11
  } org_e;

  localparam int unsigned NUM_ARRAYS = 2;
endpackage

// File: rtl/lutram_rst_sync.sv
module lutram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/lutram_array.sv
module lutram_array #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rdata
);
  logic [DEPTH-1:0] cells_q;
  logic [DEPTH-1:0] cells_d;

  always_comb begin
    cells_d        = cells_q;
    cells_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '0;
    end else if (we) begin
      cells_q <= cells_d;
    end
  end

  assign rdata = cells_q[raddr];
endmodule

// File: rtl/lutram_port_map.sv
module lutram_port_map
  import lutram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  org_e                          org,
  input  logic                          wr_en,
  input  logic                          din0,
  input  logic                          din1,
  input  logic [ADDR_W-1:0]             addr_a,
  input  logic [ADDR_W-1:0]             addr_b,
  output logic [NUM_ARRAYS-1:0]         arr_we,
  output logic [NUM_ARRAYS-1:0][ADDR_W-1:0] arr_waddr,
  output logic [NUM_ARRAYS-1:0]         arr_wdata,
  output logic [NUM_ARRAYS-1:0][ADDR_W-1:0] arr_raddr
);
  always_comb begin
    arr_we    = {NUM_ARRAYS{wr_en}};
    arr_waddr = {addr_b, addr_a};
    arr_wdata = {din1, din0};
    arr_raddr = {addr_b, addr_a};
    unique case (org)
      ORG_DEEP: begin
        arr_we    = {wr_en & din1, wr_en & ~din1};
        arr_waddr = {addr_a, addr_a};
        arr_wdata = {din0, din0};
        arr_raddr = {addr_a, addr_a};
      end
      ORG_DUAL: begin
        arr_waddr = {addr_a, addr_a};
        arr_wdata = {din0, din0};
      end
      ORG_WIDE, ORG_ALT: begin
        arr_we = {NUM_ARRAYS{wr_en}};
      end
      default: begin
        arr_we = '0;
      end
    endcase
  end
endmodule

// File: rtl/lutram_rd_mux.sv
module lutram_rd_mux
  import lutram_pkg::*;
(
  input  org_e                  org,
  input  logic                  bank_sel,
  input  logic [NUM_ARRAYS-1:0] arr_rdata,
  output logic                  dout0,
  output logic                  dout1
);
  always_comb begin
    dout0 = arr_rdata[0];
    dout1 = arr_rdata[1];
    if (org == ORG_DEEP) begin
      dout0 = bank_sel ? arr_rdata[1] : arr_rdata[0];
      dout1 = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_lut_ram.sv
module cfg_lut_ram
  import lutram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_fall_sel,
  input  logic [1:0]        org_sel,
  input  logic              wr_en,
  input  logic              din0,
  input  logic              din1,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              dout0,
  output logic              dout1
);
  org_e org;
  logic wclk;
  logic rst_sync_n;
  logic [NUM_ARRAYS-1:0]             arr_we;
  logic [NUM_ARRAYS-1:0][ADDR_W-1:0] arr_waddr;
  logic [NUM_ARRAYS-1:0]             arr_wdata;
  logic [NUM_ARRAYS-1:0][ADDR_W-1:0] arr_raddr;
  logic [NUM_ARRAYS-1:0]             arr_rdata;

  assign org  = org_e'(org_sel);
  assign wclk = clk ^ clk_fall_sel;

  lutram_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (wclk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  lutram_port_map #(.ADDR_W(ADDR_W)) i_port_map (
    .org       (org),
    .wr_en     (wr_en),
    .din0      (din0),
    .din1      (din1),
    .addr_a    (addr_a),
    .addr_b    (addr_b),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .arr_wdata (arr_wdata),
    .arr_raddr (arr_raddr)
  );

  for (genvar g = 0; g < NUM_ARRAYS; g++) begin : g_array
    lutram_array #(.ADDR_W(ADDR_W)) i_array (
      .clk   (wclk),
      .rst_n (rst_sync_n),
      .we    (arr_we[g]),
      .waddr (arr_waddr[g]),
      .wdata (arr_wdata[g]),
      .raddr (arr_raddr[g]),
      .rdata (arr_rdata[g])
    );
  end

  lutram_rd_mux i_rd_mux (
    .org       (org),
    .bank_sel  (din1),
    .arr_rdata (arr_rdata),
    .dout0     (dout0),
    .dout1     (dout1)
  );
endmodule

// File: rtl/lutram_checker.sv
module lutram_checker
  import lutram_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              wclk,
  input logic              rst_n,
  input logic [1:0]        org_sel,
  input logic              wr_en,
  input logic              din0,
  input logic              din1,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic              dout0,
  input logic              dout1
);
  AST_WIDE_WRITE_LANDS: assert property (@(posedge wclk) disable iff (!rst_n)
    ($past(wr_en) && $past(org_sel) == ORG_WIDE && org_sel == ORG_WIDE &&
     $stable(addr_a) && $stable(addr_b))
    |-> (dout0 == $past(din0) && dout1 == $past(din1))); // R2

  AST_DEEP_WRITE_LANDS: assert property (@(posedge wclk) disable iff (!rst_n)
    ($past(wr_en) && $past(org_sel) == ORG_DEEP && org_sel == ORG_DEEP &&
     $stable(addr_a) && $stable(din1))
    |-> (dout0 == $past(din0))); // R3

  AST_DEEP_UPPER_QUIET: assert property (@(posedge wclk) disable iff (!rst_n)
    (org_sel == ORG_DEEP) |-> (dout1 == 1'b0)); // R4

  AST_DUAL_WRITE_LANDS: assert property (@(posedge wclk) disable iff (!rst_n)
    ($past(wr_en) && $past(org_sel) == ORG_DUAL && org_sel == ORG_DUAL &&
     $stable(addr_a) && addr_b == addr_a)
    |-> (dout0 == $past(din0) && dout1 == $past(din0))); // R5

  AST_IDLE_EDGE_HOLDS: assert property (@(posedge wclk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(org_sel) && $stable(addr_a) &&
     $stable(addr_b) && $stable(din1))
    |-> ($stable(dout0) && $stable(dout1))); // R7
endmodule

bind cfg_lut_ram lutram_checker #(.ADDR_W(ADDR_W)) i_lutram_checker (
  .wclk    (wclk),
  .rst_n   (rst_sync_n),
  .org_sel (org_sel),
  .wr_en   (wr_en),
  .din0    (din0),
  .din1    (din1),
  .addr_a  (addr_a),
  .addr_b  (addr_b),
  .dout0   (dout0),
  .dout1   (dout1)
);

// File: tb/test_cfg_lut_ram.sv
`timescale 1ns/1ps
module test_cfg_lut_ram;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_fall_sel;
  logic [1:0] org_sel;
  logic       wr_en, din0, din1;
  logic [3:0] addr_a, addr_b;
  logic       dout0, dout1;

  int errors = 0;
  int checks = 0;
  bit ref_mem [2][16];

  always #5 clk = ~clk;

  cfg_lut_ram i_cfg_lut_ram (
    .clk(clk), .rst_n(rst_n), .clk_fall_sel(clk_fall_sel), .org_sel(org_sel),
    .wr_en(wr_en), .din0(din0), .din1(din1), .addr_a(addr_a), .addr_b(addr_b),
    .dout0(dout0), .dout1(dout1)
  );

  // {org[1:0], we, d0, d1, addr_a[3:0], addr_b[3:0]}
  localparam logic [12:0] VEC [16] = '{
    {2'b00, 1'b1, 1'b1, 1'b0, 4'd3,  4'd3 },
    {2'b00, 1'b1, 1'b0, 1'b1, 4'd5,  4'd9 },
    {2'b00, 1'b1, 1'b1, 1'b1, 4'd15, 4'd0 },
    {2'b00, 1'b0, 1'b0, 1'b0, 4'd3,  4'd9 },
    {2'b01, 1'b1, 1'b1, 1'b1, 4'd4,  4'd7 },
    {2'b01, 1'b1, 1'b1, 1'b0, 4'd6,  4'd6 },
    {2'b01, 1'b0, 1'b0, 1'b1, 4'd4,  4'd2 },
    {2'b01, 1'b0, 1'b1, 1'b0, 4'd4,  4'd9 },
    {2'b01, 1'b1, 1'b0, 1'b1, 4'd4,  4'd1 },
    {2'b10, 1'b1, 1'b1, 1'b0, 4'd8,  4'd8 },
    {2'b10, 1'b1, 1'b1, 1'b0, 4'd2,  4'd8 },
    {2'b10, 1'b1, 1'b0, 1'b1, 4'd8,  4'd8 },
    {2'b10, 1'b0, 1'b1, 1'b1, 4'd2,  4'd2 },
    {2'b10, 1'b1, 1'b1, 1'b0, 4'd0,  4'd15},
    {2'b11, 1'b1, 1'b0, 1'b1, 4'd1,  4'd14},
    {2'b00, 1'b0, 1'b0, 1'b0, 4'd15, 4'd0 }
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (org=%b a=%0d b=%0d d1=%b)",
               req, got, exp, org_sel, addr_a, addr_b, din1);
    end
  endtask

  function automatic logic exp0();
    if (org_sel == 2'b01) return ref_mem[din1][addr_a];
    return ref_mem[0][addr_a];
  endfunction

  function automatic logic exp1();
    if (org_sel == 2'b01) return 1'b0;
    return ref_mem[1][addr_b];
  endfunction

  task automatic model_write();
    if (!wr_en) return;
    case (org_sel)
      2'b01: ref_mem[din1][addr_a] = din0;
      2'b10: begin ref_mem[0][addr_a] = din0; ref_mem[1][addr_a] = din0; end
      default: begin ref_mem[0][addr_a] = din0; ref_mem[1][addr_b] = din1; end
    endcase
  endtask

  task automatic wait_inactive();
    if (clk_fall_sel) @(posedge clk); else @(negedge clk);
  endtask

  task automatic wait_active();
    if (clk_fall_sel) @(negedge clk); else @(posedge clk);
  endtask

  function automatic string mode_tag();
    case (org_sel)
      2'b01:   return "R3";
      2'b10:   return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic do_op(input logic [12:0] v);
    wait_inactive();
    #1;
    {org_sel, wr_en, din0, din1, addr_a, addr_b} = v;
    #1;
    check("R6 pre-edge", dout0, exp0());
    check("R6 pre-edge", dout1, exp1());
    wait_active();
    model_write();
    #1;
    check(mode_tag(), dout0, exp0());
    check(org_sel == 2'b01 ? "R4" : mode_tag(), dout1, exp1());
  endtask

  task automatic do_reset(input logic fall);
    rst_n = 1'b0;
    wr_en = 1'b0;
    #3;
    clk_fall_sel = fall;
    for (int i = 0; i < 16; i++) begin ref_mem[0][i] = 1'b0; ref_mem[1][i] = 1'b0; end
    #20;
    rst_n = 1'b1;
    repeat (4) wait_active();
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_fall_sel = 1'b0; org_sel = 2'b00;
    wr_en = 1'b0; din0 = 1'b0; din1 = 1'b0; addr_a = '0; addr_b = '0;

    // R1: first make the arrays non-zero, then reset and read everything back
    do_reset(1'b0);
    for (int i = 0; i < 4; i++) do_op({2'b00, 1'b1, 1'b1, 1'b1, 4'(i), 4'(i)});
    do_reset(1'b0);
    for (int i = 0; i < 16; i++) begin
      #1 addr_a = 4'(i); addr_b = 4'(15 - i); din1 = 1'b0; org_sel = 2'b00;
      #1 check("R1", dout0, 1'b0); check("R1", dout1, 1'b0);
    end

    // Table of vectors, rising edge active
    for (int i = 0; i < 16; i++) do_op(VEC[i]);

    // R6: read data follows the address with no edge in between
    wait_inactive();
    #1 org_sel = 2'b00; wr_en = 1'b0; addr_a = 4'd15; addr_b = 4'd0;
    #1 check("R6", dout0, ref_mem[0][15]);
    addr_a = 4'd3;
    #1 check("R6", dout0, ref_mem[0][3]);
    addr_b = 4'd14;
    #1 check("R6", dout1, ref_mem[1][14]);

    // R7: idle edge with data present changes nothing
    do_op({2'b00, 1'b0, 1'b1, 1'b1, 4'd7, 4'd7});
    check("R7", dout0, 1'b0);
    check("R7", dout1, 1'b0);

    // R8: falling edge is the active edge
    do_reset(1'b1);
    do_op({2'b00, 1'b1, 1'b1, 1'b1, 4'd10, 4'd11});
    check("R8", dout0, 1'b1);
    check("R8", dout1, 1'b1);
    // rising edge must not write in falling mode
    @(negedge clk);
    #1 org_sel = 2'b00; wr_en = 1'b1; din0 = 1'b1; din1 = 1'b1; addr_a = 4'd12; addr_b = 4'd13;
    @(posedge clk);
    #1 check("R8", dout0, 1'b0);
    check("R8", dout1, 1'b0);
    wr_en = 1'b0;
    do_op({2'b10, 1'b1, 1'b1, 1'b0, 4'd6, 4'd6});
    do_op({2'b01, 1'b1, 1'b1, 1'b1, 4'd9, 4'd3});

    wait_inactive();
    #1 wr_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule